// File: doc/BRIEF.md
# Binary and Packed-Decimal Accumulator Adder-Subtractor

This block adds or subtracts a memory operand to or from an accumulator, carry-in included, in binary or packed BCD, over 8 or 16 bits. A single strobe samples all inputs. One clock later the block presents the stored result and the sign, overflow, zero and carry flags, together with a one-cycle valid pulse.

Subtraction uses the same adder. The operand is one's-complemented and the carry-in counts as +1, so a carry-in of 1 means "no borrow". In decimal mode each 4-bit digit is corrected before its carry ripples into the next digit. Addition adds 6 to a digit sum above 9. Subtraction takes 6 away from a digit sum that produced no carry. The overflow flag is sampled before the top digit's correction. Digits A to F are accepted and go through the same rules.

Top module: `bcd_accum_alu`

## Requirements
- R1: `valid_o` is high for exactly the one cycle after a cycle with `start` high. In cycles without `start`, the result and flags keep their values.
- R2: A synchronous `rst` clears the result, all flags and `valid_o` to zero.
- R3: With `dec`=0 and `op_sub`=0, the result is acc + operand + `carry_in` truncated to the width. `wide`=1 selects 16 bits and `wide`=0 selects 8 bits.
- R4: With `dec`=0 and `op_sub`=1, the result is acc + ~operand + `carry_in` truncated to the width, where the complement is taken over the width.
- R5: With `dec`=1 and `op_sub`=0, each digit from the lowest up is the sum of both digits and the incoming carry. If that sum exceeds 9, 6 is added, and the digit carries out when the corrected value exceeds 15.
- R6: With `dec`=1 and `op_sub`=1, each digit is the sum of the acc digit, the complemented operand digit and the incoming carry. If that sum is at most 15, 6 is subtracted modulo 16 and there is no carry out; otherwise the digit carries out unchanged.
- R7: `flag_v` is the top bit of ~(acc ^ B') & (acc ^ R) at the selected width. B' is the operand as fed to the adder. R is the sum before the top digit's decimal correction.
- R8: `flag_c` is 1 exactly when the final sum exceeds the width maximum, that is, when the top digit (or the binary sum) carries out.
- R9: `flag_n` equals bit 15 (when `wide`=1) or bit 7 (when `wide`=0) of `result_o`. `flag_z` is 1 when the bits of the selected width are all zero.
- R10: With `wide`=0, `result_o[15:8]` equals `acc_in[15:8]` as sampled with `start`.
- R11: Digits A to F in decimal mode raise no error. The output follows the R5/R6 rules exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Sample inputs and compute |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| dec | input | 1 | 1 = packed BCD, 0 = binary |
| carry_in | input | 1 | Carry-in (1 = no borrow when subtracting) |
| acc_in | input | 16 | Accumulator operand |
| opnd_in | input | 16 | Memory operand |
| result_o | output | 16 | Registered result |
| flag_n | output | 1 | Sign of the result at the width |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Result zero at the width |
| flag_c | output | 1 | Carry out |
| valid_o | output | 1 | One-cycle result pulse |

## Verification
The hardest case to reach is a decimal result whose overflow flag differs from the overflow of the corrected value. This only happens when the top digit's uncorrected sum crosses the sign bit and the correction then moves it back, or the reverse. A random binary stream rarely produces it. Directed operands such as 0x79+0x10 and 0x80-0x01 are chosen so that the intermediate top digit sits just past 7 or wraps. A random stream over all four mode combinations, with digits A to F left in, then covers the ragged carry and borrow chains.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    parameter int unsigned ACC_W  = 16;
    parameter int unsigned HALF_W = ACC_W / 2;
    parameter int unsigned DIG_W  = 4;

    typedef struct packed {
        logic [ACC_W-1:0] res;
        logic             n;
        logic             v;
        logic             z;
        logic             c;
        logic             valid;
    } alu_state_t;
endpackage

// File: rtl/alu_digit_slice.sv
module alu_digit_slice
    import acc_alu_pkg::*;
(
    input  logic             dec,
    input  logic             sub,
    input  logic [DIG_W-1:0] a_dig,
    input  logic [DIG_W-1:0] b_dig,
    input  logic             c_in,
    output logic [DIG_W-1:0] dig_o,
    output logic             c_out,
    output logic             raw_msb
);
    localparam logic [DIG_W:0]   DEC_LIMIT = (DIG_W+1)'(10);
    localparam logic [DIG_W+1:0] DEC_ADJ   = (DIG_W+2)'(6);

    logic [DIG_W:0]   psum;
    logic [DIG_W+1:0] adj;

    always_comb begin
        psum    = {1'b0, a_dig} + {1'b0, b_dig} + {{DIG_W{1'b0}}, c_in};
        raw_msb = psum[DIG_W-1];
        adj     = {1'b0, psum} + DEC_ADJ;
        dig_o   = psum[DIG_W-1:0];
        c_out   = psum[DIG_W];
        if (dec) begin
            if (!sub) begin
                // add: correct any digit sum above nine
                if (psum >= DEC_LIMIT) begin
                    dig_o = adj[DIG_W-1:0];
                    c_out = |adj[DIG_W+1:DIG_W];
                end
            end else if (!psum[DIG_W]) begin
                // subtract: a digit without carry borrows, pull back by six
                dig_o = psum[DIG_W-1:0] - DIG_W'(6);
                c_out = 1'b0;
            end
        end
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import acc_alu_pkg::*;
#(
    parameter int NDIG   = ACC_W / DIG_W,
    parameter int NDIG_N = HALF_W / DIG_W
) (
    input  logic             wide,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] b_eff,
    input  logic [ACC_W-1:0] digs,
    input  logic [NDIG-1:0]  raw_msb,
    input  logic [NDIG-1:0]  carries,
    output logic [ACC_W-1:0] res_o,
    output logic             n_o,
    output logic             v_o,
    output logic             z_o,
    output logic             c_o
);
    localparam int DI_W = $clog2(NDIG);
    localparam int SI_W = $clog2(ACC_W);

    logic [DI_W-1:0] top_dig;
    logic [SI_W-1:0] sgn;
    logic            a_s, b_s, r_s;

    always_comb begin
        top_dig = wide ? DI_W'(NDIG - 1) : DI_W'(NDIG_N - 1);
        sgn     = wide ? SI_W'(ACC_W - 1) : SI_W'(HALF_W - 1);
        a_s     = acc_in[sgn];
        b_s     = b_eff[sgn];
        r_s     = raw_msb[top_dig];
        v_o     = ~(a_s ^ b_s) & (a_s ^ r_s);
        c_o     = carries[top_dig];
        res_o   = wide ? digs : {acc_in[ACC_W-1:HALF_W], digs[HALF_W-1:0]};
        n_o     = res_o[sgn];
        z_o     = wide ? (digs == '0) : (digs[HALF_W-1:0] == '0);
    end
endmodule

// File: rtl/bcd_accum_alu.sv
module bcd_accum_alu
    import acc_alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_sub,
    input  logic             wide,
    input  logic             dec,
    input  logic             carry_in,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] opnd_in,
    output logic [ACC_W-1:0] result_o,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_z,
    output logic             flag_c,
    output logic             valid_o
);
    localparam int NDIG   = ACC_W / DIG_W;
    localparam int NDIG_N = HALF_W / DIG_W;

    logic [ACC_W-1:0] b_eff;
    logic [ACC_W-1:0] digs;
    logic [NDIG:0]    cy;
    logic [NDIG-1:0]  raw_msb;
    logic [ACC_W-1:0] f_res;
    logic             f_n, f_v, f_z, f_c;
    alu_state_t       st_d, st_q;

    assign b_eff = op_sub ? ~opnd_in : opnd_in;
    assign cy[0] = carry_in;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        alu_digit_slice u_slice (
            .dec     (dec),
            .sub     (op_sub),
            .a_dig   (acc_in[g*DIG_W +: DIG_W]),
            .b_dig   (b_eff[g*DIG_W +: DIG_W]),
            .c_in    (cy[g]),
            .dig_o   (digs[g*DIG_W +: DIG_W]),
            .c_out   (cy[g+1]),
            .raw_msb (raw_msb[g])
        );
    end

    alu_flag_gen #(.NDIG(NDIG), .NDIG_N(NDIG_N)) u_flags (
        .wide    (wide),
        .acc_in  (acc_in),
        .b_eff   (b_eff),
        .digs    (digs),
        .raw_msb (raw_msb),
        .carries (cy[NDIG:1]),
        .res_o   (f_res),
        .n_o     (f_n),
        .v_o     (f_v),
        .z_o     (f_z),
        .c_o     (f_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (start) begin
            st_d.res   = f_res;
            st_d.n     = f_n;
            st_d.v     = f_v;
            st_d.z     = f_z;
            st_d.c     = f_c;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign flag_n   = st_q.n;
    assign flag_v   = st_q.v;
    assign flag_z   = st_q.z;
    assign flag_c   = st_q.c;
    assign valid_o  = st_q.valid;
endmodule

// File: rtl/alu_props.sv
module alu_props
    import acc_alu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             wide,
    input logic [ACC_W-1:0] acc_in,
    input logic [ACC_W-1:0] result_o,
    input logic             flag_n,
    input logic             flag_v,
    input logic             flag_z,
    input logic             flag_c,
    input logic             valid_o
);
    assert_valid_after_start_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> valid_o);

    assert_no_stray_valid_R1: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid_o);

    assert_hold_outputs_R1: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result_o) && $stable(flag_n) && $stable(flag_v)
                    && $stable(flag_z) && $stable(flag_c)));

    assert_sign_flag_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> (flag_n == ($past(wide) ? result_o[ACC_W-1] : result_o[HALF_W-1])));

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> (flag_z == ($past(wide) ? (result_o == '0) : (result_o[HALF_W-1:0] == '0))));

    assert_upper_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !wide) |=> (result_o[ACC_W-1:HALF_W] == $past(acc_in[ACC_W-1:HALF_W])));
endmodule

bind bcd_accum_alu alu_props u_props (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wide     (wide),
    .acc_in   (acc_in),
    .result_o (result_o),
    .flag_n   (flag_n),
    .flag_v   (flag_v),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .valid_o  (valid_o)
);

// File: tb/tb_bcd_accum_alu.sv
`timescale 1ns/1ps
module tb_bcd_accum_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, op_sub = 1'b0, wide = 1'b0, dec = 1'b0, carry_in = 1'b0;
    logic [15:0] acc_in = '0, opnd_in = '0;
    logic [15:0] result_o;
    logic        flag_n, flag_v, flag_z, flag_c, valid_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [15:0] last_res = '0;

    typedef struct {
        logic [15:0] res;
        logic n, v, z, c;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    bcd_accum_alu dut (
        .clk(clk), .rst(rst), .start(start), .op_sub(op_sub), .wide(wide), .dec(dec),
        .carry_in(carry_in), .acc_in(acc_in), .opnd_in(opnd_in), .result_o(result_o),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c), .valid_o(valid_o)
    );

    function automatic exp_t model(input logic [15:0] a, input logic [15:0] b, input logic cin,
                                   input logic sub, input logic wd, input logic dc, input string tag);
        exp_t e;
        int w, msk, r0, r1, res, cy, nd, v, stored, sh;
        w   = wd ? 16 : 8;
        msk = (1 << w) - 1;
        nd  = w / 4;
        r0  = int'(a) & msk;
        r1  = (sub ? ~int'(b) : int'(b)) & msk;
        cy  = int'(cin);
        if (!dc) res = r0 + r1 + cy;
        else begin
            res = 0;
            for (int i = 0; i < nd; i++) begin
                sh  = 4 * i;
                res = (r0 & (15 << sh)) + (r1 & (15 << sh)) + (cy << sh) + (res & ((1 << sh) - 1));
                if (i < nd - 1) begin
                    if (!sub && res > ((10 << sh) - 1)) res += (6 << sh);
                    if (sub && res <= ((1 << (sh + 4)) - 1)) res -= (6 << sh);
                    cy = (res > ((1 << (sh + 4)) - 1)) ? 1 : 0;
                end
            end
        end
        v = (((~(r0 ^ r1)) & (r0 ^ res)) >> (w - 1)) & 1;
        if (dc) begin
            sh = w - 4;
            if (!sub && res > ((10 << sh) - 1)) res += (6 << sh);
            if (sub && res <= msk) res -= (6 << sh);
        end
        stored = res & msk;
        e.c   = (res > msk);
        e.v   = v[0];
        e.res = wd ? stored[15:0] : {a[15:8], stored[7:0]};
        e.n   = wd ? e.res[15] : e.res[7];
        e.z   = (stored == 0);
        e.tag = tag;
        return e;
    endfunction

    task automatic do_op(input logic [15:0] a, input logic [15:0] b, input logic cin,
                         input logic sub, input logic wd, input logic dc, input string tag);
        @(negedge clk);
        acc_in = a; opnd_in = b; carry_in = cin; op_sub = sub; wide = wd; dec = dc;
        start = 1'b1;
        sb.push_back(model(a, b, cin, sub, wd, dc, tag));
        @(negedge clk);
        start = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R1 valid without start: act=1 exp=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                last_res = e.res;
                if (result_o !== e.res || flag_n !== e.n || flag_v !== e.v ||
                    flag_z !== e.z || flag_c !== e.c) begin
                    bad++;
                    $display("FAIL %s act=%h nvzc=%b%b%b%b exp=%h nvzc=%b%b%b%b", e.tag,
                             result_o, flag_n, flag_v, flag_z, flag_c,
                             e.res, e.n, e.v, e.z, e.c);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog: act=timeout exp=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state
        total++;
        if (result_o !== 16'h0 || {flag_n, flag_v, flag_z, flag_c, valid_o} !== 5'b0) begin
            bad++;
            $display("FAIL R2 act=%h/%b exp=0000/00000", result_o,
                     {flag_n, flag_v, flag_z, flag_c, valid_o});
        end

        do_op(16'h007F, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, "R3 8b add overflow");
        do_op(16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, "R3 R8 16b add wrap");
        do_op(16'h1234, 16'h4321, 1'b1, 1'b0, 1'b1, 1'b0, "R3 16b add");
        do_op(16'h0050, 16'h0030, 1'b1, 1'b1, 1'b0, 1'b0, "R4 8b sub");
        do_op(16'h0000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0, "R4 R8 16b sub borrow");
        do_op(16'h0099, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, "R5 R8 8b dec add carry");
        do_op(16'h1234, 16'h5678, 1'b0, 1'b0, 1'b1, 1'b1, "R5 16b dec add");
        do_op(16'h9999, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, "R5 R9 16b dec ripple");
        do_op(16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b1, "R6 8b dec sub");
        do_op(16'h1000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1, "R6 16b dec sub");
        do_op(16'h0079, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b1, "R7 dec add intermediate V");
        do_op(16'h0080, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b1, "R7 dec sub intermediate V");
        do_op(16'h7999, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1, "R7 16b dec V");
        do_op(16'hAB42, 16'hCD13, 1'b0, 1'b0, 1'b0, 1'b0, "R10 upper byte kept");
        do_op(16'h5500, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, "R9 R10 zero low byte");
        do_op(16'h00FA, 16'h000F, 1'b0, 1'b0, 1'b0, 1'b1, "R11 non-BCD add");
        do_op(16'hABCD, 16'hEF01, 1'b1, 1'b1, 1'b1, 1'b1, "R11 non-BCD sub");

        for (int k = 0; k < 400; k++) begin
            logic sb_s, sb_w, sb_d;
            string t;
            sb_s = 1'($urandom);
            sb_w = 1'($urandom);
            sb_d = 1'($urandom);
            t = sb_d ? (sb_s ? "R6 random" : "R5 random") : (sb_s ? "R4 random" : "R3 random");
            do_op(16'($urandom), 16'($urandom), 1'($urandom), sb_s, sb_w, sb_d, t);
        end

        // R1: no valid and held outputs while idle
        repeat (4) @(negedge clk);
        total++;
        if (valid_o !== 1'b0 || result_o !== last_res) begin
            bad++;
            $display("FAIL R1 idle act=%b/%h exp=0/%h", valid_o, result_o, last_res);
        end
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R1 missing results act=%0d exp=0", sb.size());
        end
        finish_run();
    end
endmodule